// File: doc/BRIEF.md
# Two-Level Serial Word Receiver and Bit Decoder

This block recovers 32-bit words from a two-wire return-to-zero avionics serial line. A comparator front end outside the block reports two digital levels. `line_hi` means the line sits in the one band, and `line_lo` means it sits in the zero band. The block samples both at ten times the chosen bit rate. Each sample goes into exactly one of three short history registers, for the one, zero and null states. A bit is accepted only when a clean run of one or zero samples ends in a null sample.

Accepted bits are collected least significant first. After the 32nd bit the word is latched and its parity over all 32 bits is checked against the configured sense. The word is then offered to the host as two 16-bit halves on a read bus. The read side uses valid/ready. `rd_valid` is the data-ready flag. A half is consumed on any cycle where `rd_valid` and `rd_ready` are both high. The line cannot be stalled, so the host applies no back-pressure to it. If a word completes while the previous one is still unread, the new word replaces the old one and the overrun flag is raised. `rd_ready` may be held high, and its effect depends only on the cycles where `rd_valid` is high.

Top module: `a429_rx_decoder`

## Requirements
- R1: Each sample is classified as one (`line_hi`=1, `line_lo`=0), zero (`line_hi`=0, `line_lo`=1), null (both 0) or invalid (both 1). In any sample position at most one of the three history registers holds a high. An invalid sample shifts a low into all three.
- R2: A bit is accepted only when at least 3 consecutive one (or zero) samples are followed directly by a null sample. Shorter pulses and invalid samples add no bit to the word.
- R3: Samples are taken every `DIV_HI` clocks when `rate_sel`=0 and every `DIV_LO` clocks when `rate_sel`=1. With either rate, a line bit lasts 10 samples: 5 samples of level followed by 5 samples of null.
- R4: The first received bit lands in word bit 0 and the 32nd in bit 31. The cycle after the word is latched, `rd_valid` is 1.
- R5: A run of more than 20 null samples (2 bit times) discards a partly received word. A run of exactly 20 nulls keeps it.
- R6: With `parity_even`=0, `parity_err` is 1 when the 32-bit word has an even count of ones. With `parity_even`=1, it is 1 when the count is odd.
- R7: When `repeater`=0, `sel`=0 drives word bits 15:0 on `rd_data` and `sel`=1 drives bits 31:16. The halves may be read in either order.
- R8: When `repeater`=1 (held steady while a word is pending), `sel` is ignored. The first read returns bits 15:0 and the next returns bits 31:16.
- R9: `rd_valid` falls on the cycle after both distinct halves have been consumed. Reading the same half twice leaves it high.
- R10: A word that completes while `rd_valid`=1 replaces the held word, restarts the read sequence and sets `overrun`. `overrun` and `parity_err` clear when the word is fully read.
- R11: After reset, `rd_valid`, `overrun` and `parity_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 1 | 0: divide by DIV_HI, 1: divide by DIV_LO |
| parity_even | input | 1 | Parity sense: 0 odd, 1 even |
| repeater | input | 1 | Forces lower-half-first read order |
| line_hi | input | 1 | Line is in the one band |
| line_lo | input | 1 | Line is in the zero band |
| sel | input | 1 | Half select in normal mode |
| rd_ready | input | 1 | Host takes the half shown |
| rd_valid | output | 1 | Word available (data ready) |
| rd_data | output | 16 | Selected half of the held word |
| parity_err | output | 1 | Parity of held word mismatched |
| overrun | output | 1 | Held word overwrote an unread one |

## Verification
A history register that kept a stale high, or a run counter that was off by one, would show as a word shifted by one bit position. That error is visible on `rd_data` as soon as the 32nd bit completes. A gap counter with a wrong limit would either merge a fragment into the next word or split a valid word; the 20- and 21-null boundary runs expose this within one word time. Errors in the read-side tracking show on `rd_valid` and `overrun` one cycle after the offending handshake. The bench therefore checks those flags right after each half is taken.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
  localparam int N_SYM = 3;

  typedef enum logic [1:0] {
    SYM_NULL = 2'd0,
    SYM_ONE  = 2'd1,
    SYM_ZERO = 2'd2,
    SYM_BAD  = 2'd3
  } sym_e;

  // Map the two comparator levels to a line state; both high is illegal.
  function automatic sym_e classify(input logic hi, input logic lo);
    case ({hi, lo})
      2'b10:   return SYM_ONE;
      2'b01:   return SYM_ZERO;
      2'b00:   return SYM_NULL;
      default: return SYM_BAD;
    endcase
  endfunction
endpackage

// File: rtl/a429_rx_sampler.sv
module a429_rx_sampler
  import a429_rx_pkg::*;
#(
  parameter int DIV_HI  = 2,
  parameter int DIV_LO  = 4,
  parameter int RUN_MIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_sel,
  input  logic line_hi,
  input  logic line_lo,
  output logic samp_stb,
  output logic null_stb,
  output logic bit_valid,
  output logic bit_val
);
  localparam int DIV_MAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
  localparam int CW      = (DIV_MAX > 1) ? $clog2(DIV_MAX + 1) : 1;
  localparam int SRW     = RUN_MIN + 1;

  logic [CW-1:0]  div_cnt;
  logic [CW-1:0]  div_load;
  logic           tick;
  logic           tick_q;
  logic [1:0]     code;
  logic [SRW-1:0] hist [N_SYM];
  logic [SRW-1:0] h_null, h_one, h_zero;
  logic           run_one, run_zero;

  assign div_load = rate_sel ? CW'(DIV_LO - 1) : CW'(DIV_HI - 1);
  assign tick     = (div_cnt == '0);
  assign code     = classify(line_hi, line_lo);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      tick_q  <= 1'b0;
    end else begin
      div_cnt <= tick ? div_load : div_cnt - 1'b1;
      tick_q  <= tick;
    end
  end

  // One history register per line state; the matching one takes the high.
  always_ff @(posedge clk) begin
    for (int s = 0; s < N_SYM; s++) begin
      if (!rst_n)    hist[s] <= '0;
      else if (tick) hist[s] <= {hist[s][SRW-2:0], code == 2'(s)};
    end
  end

  assign h_null   = hist[SYM_NULL];
  assign h_one    = hist[SYM_ONE];
  assign h_zero   = hist[SYM_ZERO];
  assign run_one  = &h_one[SRW-1:1];
  assign run_zero = &h_zero[SRW-1:1];

  assign samp_stb  = tick_q;
  assign null_stb  = tick_q && h_null[0];
  assign bit_valid = tick_q && h_null[0] && (run_one || run_zero);
  assign bit_val   = run_one;

  assert_hist_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((h_null & h_one) == '0) && ((h_null & h_zero) == '0) && ((h_one & h_zero) == '0));

  assert_no_bit_on_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && (h_one[0] || h_zero[0])) |-> !bit_valid);

  assert_div_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= CW'(DIV_MAX - 1));
endmodule

// File: rtl/a429_rx_assembler.sv
module a429_rx_assembler #(
  parameter int WORD_W   = 32,
  parameter int SPB      = 10,
  parameter int GAP_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_stb,
  input  logic              null_stb,
  input  logic              bit_valid,
  input  logic              bit_val,
  input  logic              parity_even,
  output logic              word_done,
  output logic [WORD_W-1:0] word_q,
  output logic              par_err_q
);
  localparam int GAP_LIM = SPB * GAP_BITS;
  localparam int GW      = $clog2(GAP_LIM + 2);
  localparam int BW      = $clog2(WORD_W);

  logic [GW-1:0]     gap_cnt;
  logic [BW-1:0]     bit_cnt;
  logic [WORD_W-2:0] shreg;
  logic [WORD_W-1:0] full;
  logic              last_bit;
  logic              timeout;

  assign full     = {bit_val, shreg};
  assign last_bit = (bit_cnt == BW'(WORD_W - 1));
  assign timeout  = null_stb && (gap_cnt == GW'(GAP_LIM));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt <= '0;
    end else if (samp_stb) begin
      if (!null_stb)                     gap_cnt <= '0;
      else if (gap_cnt <= GW'(GAP_LIM))  gap_cnt <= gap_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      word_done <= 1'b0;
      word_q    <= '0;
      par_err_q <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (bit_valid) begin
        shreg   <= {bit_val, shreg[WORD_W-2:1]};
        bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
        if (last_bit) begin
          word_done <= 1'b1;
          word_q    <= full;
          par_err_q <= ((^full) == parity_even);
        end
      end else if (timeout) begin
        bit_cnt <= '0;
      end
    end
  end

  assert_gap_discard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> (bit_cnt == '0));

  assert_word_from_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> $past(bit_valid));
endmodule

// File: rtl/a429_rx_readport.sv
module a429_rx_readport #(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_done,
  input  logic [WORD_W-1:0]   word_in,
  input  logic                par_err_in,
  input  logic                sel,
  input  logic                repeater,
  input  logic                rd_ready,
  output logic                rd_valid,
  output logic [WORD_W/2-1:0] rd_data,
  output logic                parity_err,
  output logic                overrun
);
  localparam int HALF = WORD_W / 2;

  logic [WORD_W-1:0] held;
  logic got_lo, got_hi, pick_hi, fire, lo_now, hi_now;

  assign pick_hi = repeater ? got_lo : sel;
  assign rd_data = pick_hi ? held[WORD_W-1:HALF] : held[HALF-1:0];
  assign fire    = rd_valid && rd_ready;
  assign lo_now  = got_lo || (fire && !pick_hi);
  assign hi_now  = got_hi || (fire && pick_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held       <= '0;
      rd_valid   <= 1'b0;
      parity_err <= 1'b0;
      overrun    <= 1'b0;
      got_lo     <= 1'b0;
      got_hi     <= 1'b0;
    end else if (word_done) begin
      held       <= word_in;
      parity_err <= par_err_in;
      overrun    <= rd_valid;
      rd_valid   <= 1'b1;
      got_lo     <= 1'b0;
      got_hi     <= 1'b0;
    end else if (fire) begin
      if (lo_now && hi_now) begin
        rd_valid   <= 1'b0;
        parity_err <= 1'b0;
        overrun    <= 1'b0;
        got_lo     <= 1'b0;
        got_hi     <= 1'b0;
      end else begin
        got_lo <= lo_now;
        got_hi <= hi_now;
      end
    end
  end

  assert_valid_after_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> rd_valid);

  assert_overrun_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && rd_valid) |=> overrun);

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && lo_now && hi_now && !word_done) |=> !rd_valid);

  assert_lower_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && repeater && $stable(repeater) && got_hi) |-> got_lo);
endmodule

// File: rtl/a429_rx_decoder.sv
module a429_rx_decoder #(
  parameter int DIV_HI   = 2,
  parameter int DIV_LO   = 4,
  parameter int RUN_MIN  = 3,
  parameter int SPB      = 10,
  parameter int GAP_BITS = 2,
  parameter int WORD_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rate_sel,
  input  logic                parity_even,
  input  logic                repeater,
  input  logic                line_hi,
  input  logic                line_lo,
  input  logic                sel,
  input  logic                rd_ready,
  output logic                rd_valid,
  output logic [WORD_W/2-1:0] rd_data,
  output logic                parity_err,
  output logic                overrun
);
  logic samp_stb, null_stb, bit_valid, bit_val, word_done, par_err;
  logic [WORD_W-1:0] word;

  a429_rx_sampler #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO), .RUN_MIN(RUN_MIN)) u_sampler (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .line_hi(line_hi), .line_lo(line_lo),
    .samp_stb(samp_stb), .null_stb(null_stb), .bit_valid(bit_valid), .bit_val(bit_val)
  );

  a429_rx_assembler #(.WORD_W(WORD_W), .SPB(SPB), .GAP_BITS(GAP_BITS)) u_assembler (
    .clk(clk), .rst_n(rst_n), .samp_stb(samp_stb), .null_stb(null_stb),
    .bit_valid(bit_valid), .bit_val(bit_val), .parity_even(parity_even),
    .word_done(word_done), .word_q(word), .par_err_q(par_err)
  );

  a429_rx_readport #(.WORD_W(WORD_W)) u_readport (
    .clk(clk), .rst_n(rst_n), .word_done(word_done), .word_in(word), .par_err_in(par_err),
    .sel(sel), .repeater(repeater), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .parity_err(parity_err), .overrun(overrun)
  );
endmodule

// File: tb/a429_rx_decoder_bench.sv
`timescale 1ns/1ps
module a429_rx_decoder_bench;
  localparam int DIV_HI = 2;
  localparam int DIV_LO = 4;

  logic clk = 1'b0;
  logic rst_n, rate_sel, parity_even, repeater, line_hi, line_lo, sel, rd_ready;
  logic rd_valid, parity_err, overrun;
  logic [15:0] rd_data;

  int tests = 0;
  int fails = 0;
  int cur_div = DIV_HI;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  a429_rx_decoder #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO)) u_a429_rx_decoder (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .parity_even(parity_even),
    .repeater(repeater), .line_hi(line_hi), .line_lo(line_lo), .sel(sel),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .parity_err(parity_err), .overrun(overrun)
  );

  function automatic bit exp_perr(input logic [31:0] w, input logic even);
    return ((^w) == even);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hold(input logic h, input logic l, input int samples);
    line_hi = h;
    line_lo = l;
    repeat (samples * cur_div) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    hold(b, !b, 5);
    hold(1'b0, 1'b0, 5);
  endtask

  task automatic send_range(input logic [31:0] w, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) send_bit(w[i]);
  endtask

  task automatic send_word(input logic [31:0] w);
    send_range(w, 0, 31);
    hold(1'b0, 1'b0, 30);
  endtask

  task automatic set_rate(input logic r);
    rate_sel = r;
    cur_div = r ? DIV_LO : DIV_HI;
    hold(1'b0, 1'b0, 30);
  endtask

  task automatic read_half(input logic s, output logic [15:0] d);
    @(negedge clk);
    sel = s;
    rd_ready = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  // Read both halves in the given order and check data and flags.
  task automatic take_word(input logic [31:0] w, input logic first_hi, input string req);
    logic [15:0] d0, d1, e0, e1;
    read_half(first_hi, d0);
    check(rd_valid === 1'b1, {req, " valid after one half (R9)"}, {31'd0, rd_valid}, 32'd1);
    read_half(!first_hi, d1);
    if (repeater) begin
      e0 = w[15:0];
      e1 = w[31:16];
    end else begin
      e0 = first_hi ? w[31:16] : w[15:0];
      e1 = first_hi ? w[15:0] : w[31:16];
    end
    check(d0 === e0, {req, " first half"}, {16'd0, d0}, {16'd0, e0});
    check(d1 === e1, {req, " second half"}, {16'd0, d1}, {16'd0, e1});
    check(rd_valid === 1'b0 && overrun === 1'b0 && parity_err === 1'b0,
          {req, " flags clear after both halves (R9 R10)"},
          {29'd0, rd_valid, overrun, parity_err}, 32'd0);
  endtask

  task automatic expect_ready(input logic [31:0] w, input logic ovr, input string req);
    check(rd_valid === 1'b1, {req, " rd_valid (R4)"}, {31'd0, rd_valid}, 32'd1);
    check(parity_err === exp_perr(w, parity_even), {req, " parity_err (R6)"},
          {31'd0, parity_err}, {31'd0, exp_perr(w, parity_even)});
    check(overrun === ovr, {req, " overrun (R10)"}, {31'd0, overrun}, {31'd0, ovr});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, w2;
    logic [15:0] d;
    void'($urandom(32'd7411));
    rst_n = 1'b0; rate_sel = 1'b0; parity_even = 1'b0; repeater = 1'b0;
    line_hi = 1'b0; line_lo = 1'b0; sel = 1'b0; rd_ready = 1'b0;
    repeat (5) @(negedge clk);
    check(rd_valid === 1'b0 && overrun === 1'b0 && parity_err === 1'b0, "R11 reset state",
          {29'd0, rd_valid, overrun, parity_err}, 32'd0);
    rst_n = 1'b1;
    hold(1'b0, 1'b0, 30);

    // R4 R7: bit order, upper half read first in normal mode.
    w = 32'h8C31_F006;
    send_word(w);
    expect_ready(w, 1'b0, "R4 directed");
    take_word(w, 1'b1, "R7 upper-first");

    // R6: even parity sense on a word with odd ones count.
    parity_even = 1'b1;
    w = 32'h0000_0007;
    send_word(w);
    expect_ready(w, 1'b0, "R6 even sense");
    take_word(w, 1'b0, "R7 lower-first");
    parity_even = 1'b0;

    // R9: same half twice keeps rd_valid.
    w = 32'h1234_ABCD;
    send_word(w);
    read_half(1'b0, d);
    read_half(1'b0, d);
    check(rd_valid === 1'b1, "R9 same half twice keeps valid", {31'd0, rd_valid}, 32'd1);
    read_half(1'b1, d);
    check(d === 16'h1234, "R9 upper data", {16'd0, d}, 32'h1234);
    check(rd_valid === 1'b0, "R9 valid drops", {31'd0, rd_valid}, 32'd0);

    // R8: repeater mode ignores sel, lower half comes first.
    repeater = 1'b1;
    w = 32'hFACE_0B0E;
    send_word(w);
    take_word(w, 1'b1, "R8 repeater");
    repeater = 1'b0;

    // R10: second word overwrites unread first.
    w = 32'h0F0F_1111;
    w2 = 32'h7E57_C0DE;
    send_word(w);
    send_word(w2);
    expect_ready(w2, 1'b1, "R10 overrun");
    take_word(w2, 1'b0, "R10 overrun data");

    // R2 R1: short pulses and invalid samples inside a word add no bit.
    w = 32'hC3A5_5A3C;
    send_range(w, 0, 15);
    hold(1'b1, 1'b0, 2); hold(1'b0, 1'b0, 5);
    hold(1'b1, 1'b1, 5); hold(1'b0, 1'b0, 5);
    hold(1'b0, 1'b1, 2); hold(1'b0, 1'b0, 5);
    send_range(w, 16, 31);
    hold(1'b0, 1'b0, 30);
    expect_ready(w, 1'b0, "R2 glitches dropped");
    take_word(w, 1'b0, "R2 R1 glitch word");

    // R5: fragment followed by a 21-null run is discarded.
    w2 = 32'hFFFF_FFFF;
    send_range(w2, 0, 9);
    hold(1'b0, 1'b0, 16);
    w = 32'h5555_AAAA;
    send_word(w);
    expect_ready(w, 1'b0, "R5 discard");
    take_word(w, 1'b0, "R5 discarded fragment");

    // R5 boundary: a 20-null run keeps the partial word.
    w = 32'h9B1D_26E4;
    send_range(w, 0, 15);
    hold(1'b0, 1'b0, 15);
    send_range(w, 16, 31);
    hold(1'b0, 1'b0, 30);
    expect_ready(w, 1'b0, "R5 boundary");
    take_word(w, 1'b1, "R5 20-null kept");

    // R3: low rate.
    set_rate(1'b1);
    w = 32'h3141_5926;
    send_word(w);
    expect_ready(w, 1'b0, "R3 low rate");
    take_word(w, 1'b0, "R3 low rate data");

    // Random words, rates, parity senses, modes and read orders.
    for (int n = 0; n < 10; n++) begin
      set_rate(1'($urandom % 2));
      parity_even = 1'($urandom % 2);
      repeater = 1'($urandom % 2);
      w = $urandom;
      send_word(w);
      expect_ready(w, 1'b0, "R4 R6 random");
      take_word(w, 1'($urandom % 2), repeater ? "R8 random" : "R7 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule